// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned words of `WIDTH` bits using a single full-adder cell that is reused once per clock. Each operand sits in its own shift register with a parallel load path. The low-order bits of the two registers feed the full adder. The sum bit enters the top of the first register, and a carry flip-flop passes the carry from one bit position to the next. After exactly `WIDTH` shifts the first register holds the sum, and the carry flip-flop holds the carry out of the most significant bit.

A one-cycle `start` pulse, given while the block is idle, loads both operands, clears the carry and the bit counter, and raises `busy`. The block then shifts once per clock. After the last shift it drops `busy` and pulses `done` for one cycle. Between operations all state holds. A parameter selects what enters the second register's serial input. It can either recirculate the register's own serial output, so that the operand is preserved, or take zeros, so that the register is left empty.

Top module: `bitser_add`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `carry_out`, `result` and `b_hold` are all zero.
- R2: A `start` sampled while `busy` is low loads `op_a` into `result` and `op_b` into `b_hold`, clears the carry, and sets `busy`, all visible in the next cycle.
- R3: After an accepted start, `busy` stays high for exactly `WIDTH` cycles. `done` is high for exactly one cycle, the one after the last shift, and in that cycle `busy` is low.
- R4: In the `done` cycle, `result` equals (A + B) mod 2^WIDTH, where A and B are the operands loaded at start.
- R5: In the `done` cycle, `carry_out` equals bit `WIDTH` of A + B.
- R6: Operands are consumed least significant bit first. After k shifts (1 ≤ k ≤ WIDTH), the top k bits of `result` hold sum bits k-1 down to 0.
- R7: With `B_FILL` = FILL_RECIRC, `b_hold` equals B in the `done` cycle. With `B_FILL` = FILL_ZERO, `b_hold` is zero in the `done` cycle.
- R8: A `start` that arrives while `busy` is high is ignored. The running addition finishes on schedule with its original operands.
- R9: While idle with no `start`, `result`, `carry_out` and `b_hold` keep their values and `done` stays low.
- R10: A `start` given in the `done` cycle is accepted, so additions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an addition; ignored while busy |
| op_a | input | WIDTH | First operand, loaded at start |
| op_b | input | WIDTH | Second operand, loaded at start |
| busy | output | 1 | High while shifting |
| done | output | 1 | One-cycle pulse after the final shift |
| result | output | WIDTH | First operand register; holds the sum when done |
| carry_out | output | 1 | Carry flip-flop; final carry when done |
| b_hold | output | WIDTH | Second operand register contents |

## Verification
The bench builds the main instance with `WIDTH` = 8 and `B_FILL` = FILL_RECIRC. At this size random operands reach the full carry chain, the wrap of all-ones plus one, and the mid-operation bit ordering at little cost. A second instance with `WIDTH` = 4 and `B_FILL` = FILL_ZERO covers the zero-fill variant and a short counter. The main instance also sees back-to-back starts in the `done` cycle, and starts issued in the middle of an addition with operands that would change the result if they were taken.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
   typedef enum logic {
      FILL_RECIRC = 1'b0,
      FILL_ZERO   = 1'b1
   } fill_e;

   function automatic int cnt_bits(input int w);
      return (w > 1) ? $clog2(w) : 1;
   endfunction
endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic [WIDTH-1:0] q,
   output logic             ser_out
);
   initial begin : chk_width
      if (WIDTH < 1) $fatal(1, "bsa_shreg: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] nxt;

   generate
      if (WIDTH == 1) begin : g_single
         always_comb nxt = ser_in;
      end else begin : g_multi
         always_comb nxt = {ser_in, q[WIDTH-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (load)  q <= par_in;
      else if (shift) q <= nxt;
   end

   assign ser_out = q[0];

   // R9: register holds when neither loading nor shifting
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!load && !shift) |=> $stable(q));
endmodule

// File: rtl/bsa_fa_carry.sv
module bsa_fa_carry (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic en,
   input  logic x,
   input  logic y,
   output logic sum,
   output logic carry_q
);
   logic cy_nxt;

   always_comb begin
      sum    = x ^ y ^ carry_q;
      cy_nxt = (x & y) | (x & carry_q) | (y & carry_q);
   end

   always_ff @(posedge clk) begin
      if (rst || clear) carry_q <= 1'b0;
      else if (en)      carry_q <= cy_nxt;
   end

   // R2: a cleared carry is zero in the next cycle
   p_carry_clear_r2: assert property (@(posedge clk) disable iff (rst)
      clear |=> !carry_q);
   // R9: carry holds while not enabled
   p_carry_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!clear && !en) |=> $stable(carry_q));
endmodule

// File: rtl/bsa_seq.sv
module bsa_seq #(
   parameter int WIDTH = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic shift,
   output logic busy,
   output logic done
);
   localparam int CNT_W = bsa_pkg::cnt_bits(WIDTH);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   initial begin : chk_width
      if (WIDTH < 1) $fatal(1, "bsa_seq: WIDTH must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             at_last;

   assign load    = start & ~busy;
   assign shift   = busy;
   assign at_last = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else if (load) begin
         cnt  <= '0;
         busy <= 1'b1;
         done <= 1'b0;
      end else if (busy) begin
         cnt  <= cnt + 1'b1;
         busy <= ~at_last;
         done <= at_last;
      end else begin
         done <= 1'b0;
      end
   end

   // R3: the final shift ends busy and raises done
   p_last_shift_r3: assert property (@(posedge clk) disable iff (rst)
      (busy && at_last) |=> (done && !busy));
   // R3: done is a single-cycle pulse
   p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R8: start while busy does not cut the operation short
   p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
      (busy && !at_last) |=> busy);
   // R3: counter stays within the word
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
      busy |-> (cnt <= LAST));
endmodule

// File: rtl/bitser_add.sv
module bitser_add #(
   parameter int            WIDTH  = 16,
   parameter bsa_pkg::fill_e B_FILL = bsa_pkg::FILL_RECIRC
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic [WIDTH-1:0] b_hold
);
   initial begin : chk_width
      if (WIDTH < 1) $fatal(1, "bitser_add: WIDTH must be at least 1");
   end

   logic load, shift;
   logic a_ser, b_ser, b_fill, sum_bit;

   bsa_seq #(.WIDTH(WIDTH)) u_seq (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .load  (load),
      .shift (shift),
      .busy  (busy),
      .done  (done)
   );

   bsa_shreg #(.WIDTH(WIDTH)) u_reg_a (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .shift   (shift),
      .par_in  (op_a),
      .ser_in  (sum_bit),
      .q       (result),
      .ser_out (a_ser)
   );

   generate
      if (B_FILL == bsa_pkg::FILL_RECIRC) begin : g_b_recirc
         assign b_fill = b_ser;
      end else begin : g_b_zero
         assign b_fill = 1'b0;
      end
   endgenerate

   bsa_shreg #(.WIDTH(WIDTH)) u_reg_b (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .shift   (shift),
      .par_in  (op_b),
      .ser_in  (b_fill),
      .q       (b_hold),
      .ser_out (b_ser)
   );

   bsa_fa_carry u_fa (
      .clk     (clk),
      .rst     (rst),
      .clear   (load),
      .en      (shift),
      .x       (a_ser),
      .y       (b_ser),
      .sum     (sum_bit),
      .carry_q (carry_out)
   );

   // R2: an accepted start shows the first operand in the next cycle
   p_load_a_r2: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> (result == $past(op_a) && busy));
   // R2: second operand loaded alongside
   p_load_b_r2: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> (b_hold == $past(op_b)));
   // R9: idle without start keeps the result
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> ($stable(result) && $stable(carry_out) && !done));
endmodule

// File: tb/bitser_add_test.sv
`timescale 1ns/1ps
module bitser_add_test;
   localparam int W  = 8;
   localparam int WZ = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0;
   logic busy, done, carry_out;
   logic [W-1:0] result, b_hold;

   logic start_z = 1'b0;
   logic [WZ-1:0] za = '0, zb = '0;
   logic busy_z, done_z, cout_z;
   logic [WZ-1:0] res_z, bh_z;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   bitser_add #(.WIDTH(W), .B_FILL(bsa_pkg::FILL_RECIRC)) uut (
      .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
      .busy(busy), .done(done), .result(result), .carry_out(carry_out),
      .b_hold(b_hold));

   bitser_add #(.WIDTH(WZ), .B_FILL(bsa_pkg::FILL_ZERO)) uut_z (
      .clk(clk), .rst(rst), .start(start_z), .op_a(za), .op_b(zb),
      .busy(busy_z), .done(done_z), .result(res_z), .carry_out(cout_z),
      .b_hold(bh_z));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic longint exp_sum(input longint a, input longint b);
      return a + b;
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Run one addition from a negedge; returns at the negedge of the done cycle.
   task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
      longint full;
      full  = exp_sum(a, b);
      start = 1'b1; op_a = a; op_b = b;
      tick();
      start = 1'b0;
      op_a = ~a; op_b = b ^ 8'h5A;
      chk(result == a && b_hold == b, "R2 load", {result, b_hold}, {a, b});
      chk(busy == 1'b1 && carry_out == 1'b0, "R2 busy/carry", {busy, carry_out}, 2'b10);
      for (int k = 1; k <= W; k++) begin
         if (poke && (k == 2 || k == W - 1)) start = 1'b1;  // R8 stray start
         tick();
         start = 1'b0;
         if (k < W) begin
            chk(busy == 1'b1 && done == 1'b0, "R3 busy during shifts", {busy, done}, 2'b10);
            if (k == W / 2 || k == 1)
               chk((longint'(result) >> (W - k)) == (full & ((64'd1 << k) - 1)),
                   "R6 lsb-first partial sum", longint'(result) >> (W - k),
                   full & ((64'd1 << k) - 1));
         end else begin
            chk(busy == 1'b0 && done == 1'b1, "R3 done pulse", {busy, done}, 2'b01);
            chk(result == W'(full), poke ? "R8/R4 sum" : "R4 sum", result, W'(full));
            chk(carry_out == full[W], "R5 carry", carry_out, full[W]);
            chk(b_hold == b, "R7 b recirculated", b_hold, b);
         end
      end
   endtask

   task automatic idle_check(input int n);
      logic [W-1:0] r0, b0;
      logic c0;
      r0 = result; b0 = b_hold; c0 = carry_out;
      for (int i = 0; i < n; i++) begin
         tick();
         chk(result == r0 && b_hold == b0 && carry_out == c0 && done == 1'b0 && busy == 1'b0,
             "R9 idle hold", {result, b_hold, carry_out, done}, {r0, b0, c0, 1'b0});
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      longint fz;
      void'($urandom(32'd7719));
      @(negedge clk);
      tick(); tick();
      chk(busy == 0 && done == 0 && carry_out == 0 && result == 0 && b_hold == 0,
          "R1 reset", {busy, done, carry_out, result, b_hold}, 0);
      rst = 1'b0;
      tick();
      // directed corners
      run_add(8'h00, 8'h00, 1'b0); idle_check(2);
      run_add(8'hFF, 8'h01, 1'b0); idle_check(1);
      run_add(8'hFF, 8'hFF, 1'b0); idle_check(1);
      run_add(8'h80, 8'h80, 1'b1); idle_check(2);
      // R10: back-to-back, start in the done cycle
      run_add(8'h3C, 8'hC5, 1'b0);
      run_add(8'h7F, 8'h01, 1'b0);
      idle_check(1);
      // R8: start while busy, random operands
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] ra, rb;
         ra = W'($urandom); rb = W'($urandom);
         run_add(ra, rb, ($urandom % 3) == 0);
         if (($urandom % 2) == 0) idle_check(1 + int'($urandom % 3));
      end
      idle_check(1);
      // zero-fill variant
      za = 4'hB; zb = 4'h7; start_z = 1'b1;
      tick();
      start_z = 1'b0;
      chk(res_z == 4'hB && bh_z == 4'h7 && busy_z, "R2 load (zero-fill)", {res_z, bh_z}, 8'hB7);
      repeat (WZ) tick();
      fz = exp_sum(4'hB, 4'h7);
      chk(done_z == 1'b1 && busy_z == 1'b0, "R3 done (zero-fill)", {busy_z, done_z}, 2'b01);
      chk(res_z == WZ'(fz) && cout_z == fz[WZ], "R4/R5 zero-fill sum", {cout_z, res_z}, fz);
      chk(bh_z == 4'h0, "R7 b zero-filled", bh_z, 0);
      tick();
      chk(done_z == 1'b0, "R3 single done (zero-fill)", done_z, 0);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule